// File: doc/BRIEF.md
# Programmable Pixel Colour Matrix

This block applies a programmable 3x3 matrix to a stream of pixels that carry three 12-bit channels. Each pixel is processed independently. Before the multiply, a signed offset is added to every input channel. Each output channel is then the sum of the three offset inputs, each weighted by its own signed coefficient. That sum is divided by a selectable power of two and rounded, an output offset is added, and the result is clamped to the 12-bit range. One typical setting uses a diagonal gain of 0x36F, a divisor of 1024 and an output offset of 0x040. This setting compresses full-range RGB into limited-range RGB before it goes to a display link.

Configuration arrives through a byte-wide write/read port and is held in a pending bank. The pending bank is copied into the working bank on a frame-start pulse, so settings never change in the middle of a frame. The frame-start pulse is expected to arrive during blanking. A bypass flag sends pixels straight through the same three-stage delay and stops the arithmetic registers from toggling. A width field zeroes the low bits of the input for 10-bit or 8-bit sources.

Top module: `cmx_matrix`

## Requirements
- R1: The register window spans byte addresses 0x80 to 0x9E.
  - 0x80 is control: bit 0 is bypass, bits 2:1 are the scale select, bits 4:3 are the width select, and bits 7:5 read as zero.
  - 0x81..0x86 hold the input offsets for G/Y, R/CR and B/CB.
  - 0x87..0x98 hold nine coefficients, row by row: the G/Y output row, then the R/CR row, then the B/CB row. Within a row they are ordered by input G/Y, R/CR, B/CB.
  - 0x99..0x9E hold the output offsets in the same channel order.
  - Every value takes an upper byte at the odd address, holding bits 10:8 in bits 2:0, followed by a lower byte holding bits 7:0.
  - Reads return the pending value, with unused upper-byte bits read as zero. Reads outside the window return 0.
- R2: After reset, control reads 0x05 (bypass on, scale select 2, width 12-bit), every other register reads 0, and pix_valid_o is low.
- R3: Register writes change the pixel outputs only after the next cycle in which frame_start is high. Until then the previous working settings stay in force.
- R4: With bypass set, each output pixel equals its (width-masked) input pixel.
- R5: With bypass clear, each output channel r equals sum over c of (in[c] + 4*inofs[c]) * coef[r][c], scaled, plus 4*outofs[r]. Offsets and coefficients are 11-bit two's complement values.
- R6: The divisor is 2^(8+scale select), so select values 0..3 divide by 256, 512, 1024 and 2048.
- R7: The scaled sum is rounded to nearest, with halves going toward positive infinity. For example, a sum of 512 at divisor 1024 gives 1, and a sum of 511 gives 0.
- R8: Results below 0 are output as 0, and results above 4095 are output as 4095.
- R9: Width select 1 clears bits 1:0 of every input channel. Width select 2 clears bits 3:0. Values 0 and 3 keep all 12 bits. The masking applies in both modes.
- R10: pix_valid_o equals pix_valid_i delayed by exactly three clock cycles, in both modes. Pixels leave in arrival order, one per input pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| frame_start | input | 1 | One-cycle pulse that copies the pending settings to the working bank |
| pix_valid_i | input | 1 | Input pixel qualifier |
| pix_data_i | input | 36 | Input pixel: G/Y in bits 11:0, R/CR in bits 23:12, B/CB in bits 35:24 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Pending register value at reg_addr (combinational) |
| pix_valid_o | output | 1 | Output pixel qualifier |
| pix_data_o | output | 36 | Output pixel, same channel layout as the input |

## Verification
A corrupted working register would show on the very next active-mode pixel, three cycles after it enters. A sweep of channel values that reaches both clamp limits and both signs of the intermediate sum is therefore enough to expose a wrong coefficient, offset, rounding step or scale shift. A pending bank that leaks into the working bank before frame_start would show as active-mode output while the bench still expects bypass output. A valid or bypass flag that is misaligned in the pipeline would show as a lost, duplicated or out-of-order pixel. The bench's ordered expectation queue catches that at the first affected output cycle.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
  parameter int unsigned PIX_W    = 12;
  parameter int unsigned NCH      = 3;
  parameter int unsigned COEF_W   = 11;
  parameter int unsigned FRAC_MIN = 8;
  parameter logic [7:0]  REG_BASE = 8'h80;

  localparam int unsigned NFIELD = NCH * (NCH + 2);
  localparam int unsigned NREG   = 1 + 2 * NFIELD;
  localparam int unsigned OFS_SH = PIX_W - 10;
  localparam int unsigned S1_W   = PIX_W + 2;
  localparam int unsigned ACC_W  = S1_W + COEF_W + 2;

  typedef struct packed {
    logic [1:0] width;
    logic [1:0] scale;
    logic       bypass;
  } ctrl_t;
endpackage

// File: rtl/cmx_regs.sv
module cmx_regs
  import cmx_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_start,
  input  logic                          reg_we,
  input  logic [7:0]                    reg_addr,
  input  logic [7:0]                    reg_wdata,
  output logic [7:0]                    reg_rdata,
  output ctrl_t                         ctrl,
  output logic [NCH-1:0][COEF_W-1:0]     in_ofs,
  output logic [NCH*NCH-1:0][COEF_W-1:0] coef,
  output logic [NCH-1:0][COEF_W-1:0]     out_ofs
);
  localparam logic [7:0] RST_CTRL = 8'h05;

  logic [NREG-1:0][7:0]       pend_q, pend_d, work_q, work_d;
  logic [NFIELD-1:0][COEF_W-1:0] fld;
  logic [7:0] idx;
  logic       hit;

  function automatic logic [7:0] keep_bits(input logic [7:0] i);
    if (i == 8'd0)  return 8'h1F;
    else if (i[0])  return 8'h07;
    else            return 8'hFF;
  endfunction

  always_comb begin
    idx = reg_addr - REG_BASE;
    hit = (reg_addr >= REG_BASE) && (idx < 8'(NREG));
  end

  always_comb begin
    pend_d = pend_q;
    if (reg_we && hit) pend_d[idx[4:0]] = reg_wdata & keep_bits(idx);
    work_d = frame_start ? pend_q : work_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      pend_q[0] <= RST_CTRL;
      work_q    <= '0;
      work_q[0] <= RST_CTRL;
    end else begin
      pend_q <= pend_d;
      work_q <= work_d;
    end
  end

  assign reg_rdata = hit ? pend_q[idx[4:0]] : 8'h00;
  assign ctrl      = ctrl_t'(work_q[0][4:0]);

  for (genvar k = 0; k < NFIELD; k++) begin : g_fld
    assign fld[k] = {work_q[1+2*k][COEF_W-9:0], work_q[2+2*k]};
  end
  for (genvar c = 0; c < NCH; c++) begin : g_ofs
    assign in_ofs[c]  = fld[c];
    assign out_ofs[c] = fld[NCH + NCH*NCH + c];
  end
  for (genvar j = 0; j < NCH*NCH; j++) begin : g_coef
    assign coef[j] = fld[NCH + j];
  end

  // R1: upper bytes never read back bits above 10:8
  a_r1_msb_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && idx[0]) |-> (reg_rdata[7:3] == 5'd0));
  // R3: working bank only moves after a frame_start cycle
  a_r3_hold_until_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(work_q));
endmodule

// File: rtl/cmx_row.sv
module cmx_row
  import cmx_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        acc_en,
  input  logic [NCH-1:0][S1_W-1:0]    s1,
  input  logic [NCH-1:0][COEF_W-1:0]  cf,
  input  logic [1:0]                  scale,
  input  logic [COEF_W-1:0]           oofs,
  output logic [PIX_W-1:0]            y
);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((2 ** PIX_W) - 1);

  logic signed [ACC_W-1:0] acc_d, acc_q, half, rnd, ofs_x, val;
  logic [3:0] sh_amt;

  always_comb begin
    acc_d = '0;
    for (int c = 0; c < NCH; c++)
      acc_d = acc_d + ACC_W'($signed(s1[c])) * ACC_W'($signed(cf[c]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  always_comb begin
    sh_amt = 4'(FRAC_MIN) + {2'b00, scale};
    half   = ACC_W'(1) <<< (sh_amt - 4'd1);
    rnd    = (acc_q + half) >>> sh_amt;
    ofs_x  = ACC_W'($signed(oofs)) <<< OFS_SH;
    val    = rnd + ofs_x;
    if (val < 0)         y = '0;
    else if (val > MAXV) y = '1;
    else                 y = val[PIX_W-1:0];
  end
endmodule

// File: rtl/cmx_matrix.sv
module cmx_matrix
  import cmx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic                 pix_valid_i,
  input  logic [NCH*PIX_W-1:0] pix_data_i,
  input  logic                 reg_we,
  input  logic [7:0]           reg_addr,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  output logic                 pix_valid_o,
  output logic [NCH*PIX_W-1:0] pix_data_o
);
  ctrl_t                         ctrl;
  logic [NCH-1:0][COEF_W-1:0]     in_ofs, out_ofs;
  logic [NCH*NCH-1:0][COEF_W-1:0] coef;

  logic [NCH-1:0][PIX_W-1:0] pin, pm, y_all;
  logic [PIX_W-1:0]          wmask;
  logic [NCH-1:0][S1_W-1:0]  s1_d, s1_q;
  logic [NCH*PIX_W-1:0]      r1_q, r2_q, o_d;
  logic v1_q, v2_q, b1_q, b2_q;
  logic s1_en, r1_en, acc_en, r2_en, o_en;

  cmx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ctrl(ctrl), .in_ofs(in_ofs),
    .coef(coef), .out_ofs(out_ofs)
  );

  assign pin = pix_data_i;

  always_comb begin
    case (ctrl.width)
      2'd1:    wmask = {PIX_W{1'b1}} << 2;
      2'd2:    wmask = {PIX_W{1'b1}} << 4;
      default: wmask = {PIX_W{1'b1}};
    endcase
  end

  for (genvar c = 0; c < NCH; c++) begin : g_in
    assign pm[c]   = pin[c] & wmask;
    assign s1_d[c] = S1_W'(pm[c]) + (S1_W'($signed(in_ofs[c])) << OFS_SH);
  end

  always_comb begin
    s1_en  = pix_valid_i & ~ctrl.bypass;
    r1_en  = pix_valid_i &  ctrl.bypass;
    acc_en = v1_q & ~b1_q;
    r2_en  = v1_q &  b1_q;
    o_en   = v2_q;
    o_d    = b2_q ? r2_q : y_all;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0; b1_q <= 1'b0;
      v2_q <= 1'b0; b2_q <= 1'b0;
      pix_valid_o <= 1'b0;
    end else begin
      v1_q <= pix_valid_i; b1_q <= ctrl.bypass;
      v2_q <= v1_q;        b2_q <= b1_q;
      pix_valid_o <= v2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0; r1_q <= '0; r2_q <= '0; pix_data_o <= '0;
    end else begin
      if (s1_en) s1_q       <= s1_d;
      if (r1_en) r1_q       <= pm;
      if (r2_en) r2_q       <= r1_q;
      if (o_en)  pix_data_o <= o_d;
    end
  end

  for (genvar r = 0; r < NCH; r++) begin : g_row
    cmx_row u_row (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .s1(s1_q),
      .cf(coef[r*NCH +: NCH]), .scale(ctrl.scale),
      .oofs(out_ofs[r]), .y(y_all[r])
    );
  end

  // cycles since reset, saturating, used to bound $past windows
  logic [1:0] cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cyc_q <= 2'd0;
    else if (cyc_q != 2'd3)   cyc_q <= cyc_q + 2'd1;
  end

  // R10: valid delayed by exactly three cycles
  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == 2'd3) |-> (pix_valid_o == $past(pix_valid_i, 3)));
  // R4: bypassed pixel emerges unchanged
  a_r4_bypass_data: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == 2'd3 && pix_valid_o && $past(pix_valid_i, 3) && $past(ctrl.bypass, 3))
      |-> (pix_data_o == $past(pm, 3)));
  // R4: arithmetic front stage frozen while bypassed
  a_r4_arith_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.bypass |=> $stable(s1_q));
endmodule

// File: tb/sim_cmx_matrix.sv
module sim_cmx_matrix;
  logic clk = 1'b0;
  logic rst_n, frame_start, pix_valid_i, reg_we, pix_valid_o;
  logic [35:0] pix_data_i, pix_data_o;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;

  always #10 clk = ~clk;

  cmx_matrix u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .pix_valid_i(pix_valid_i), .pix_data_i(pix_data_i),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pix_valid_o(pix_valid_o), .pix_data_o(pix_data_o)
  );

  int n_chk = 0, n_fail = 0;
  string tag = "R4";
  logic [35:0] expq[$];

  // working (a_) and pending (p_) model settings
  int a_byp = 1, a_sc = 2, a_w = 0;
  int a_io[3] = '{0,0,0}, a_oo[3] = '{0,0,0}, a_cf[9] = '{0,0,0,0,0,0,0,0,0};
  int p_byp, p_sc, p_w;
  int p_io[3], p_oo[3], p_cf[9];

  task automatic chk(input bit ok, input string t, input longint got, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got %0h expected %0h", t, got, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  function automatic logic [35:0] model(input logic [35:0] d);
    logic [35:0] r;
    int m[3];
    int acc, v, sh;
    for (int c = 0; c < 3; c++) begin
      m[c] = int'(d[12*c +: 12]);
      if (a_w == 1) m[c] = m[c] & ~3;
      if (a_w == 2) m[c] = m[c] & ~15;
      r[12*c +: 12] = 12'(m[c]);
    end
    if (a_byp != 0) return r;
    sh = 8 + a_sc;
    for (int rr = 0; rr < 3; rr++) begin
      acc = 0;
      for (int c = 0; c < 3; c++) acc += (m[c] + a_io[c] * 4) * a_cf[rr*3 + c];
      v = (acc + (1 << (sh - 1))) >>> sh;
      v = v + a_oo[rr] * 4;
      if (v < 0) v = 0;
      if (v > 4095) v = 4095;
      r[12*rr +: 12] = 12'(v);
    end
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n && pix_valid_o) begin
      if (expq.size() == 0) chk(1'b0, {tag, " unexpected pixel"}, pix_data_o, 0);
      else begin
        logic [35:0] e;
        e = expq.pop_front();
        chk(pix_data_o == e, tag, pix_data_o, e);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int e, input string t);
    @(negedge clk);
    reg_addr = 8'(a);
    #1;
    chk(reg_rdata == 8'(e), t, reg_rdata, e);
  endtask

  task automatic put_val(input int base, input int v);
    wr(base, (v >> 8) & 7);
    wr(base + 1, v & 255);
  endtask

  task automatic put_cfg();
    wr(8'h80, (p_w << 3) | (p_sc << 1) | p_byp);
    for (int c = 0; c < 3; c++) put_val(8'h81 + 2*c, p_io[c]);
    for (int j = 0; j < 9; j++) put_val(8'h87 + 2*j, p_cf[j]);
    for (int c = 0; c < 3; c++) put_val(8'h99 + 2*c, p_oo[c]);
  endtask

  task automatic pulse();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    a_byp = p_byp; a_sc = p_sc; a_w = p_w;
    a_io = p_io; a_oo = p_oo; a_cf = p_cf;
  endtask

  task automatic send(input logic [35:0] d);
    @(negedge clk);
    pix_valid_i = 1'b1; pix_data_i = d;
    expq.push_back(model(d));
  endtask

  task automatic send_exp(input logic [35:0] d, input logic [35:0] e);
    @(negedge clk);
    pix_valid_i = 1'b1; pix_data_i = d;
    expq.push_back(e);
  endtask

  task automatic drain();
    @(negedge clk); pix_valid_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(expq.size() == 0, "R10 drain", expq.size(), 0);
  endtask

  task automatic sweep(input string t);
    int vals[8] = '{0, 1, 585, 1170, 2047, 2048, 3500, 4095};
    int n = 0;
    tag = t;
    for (int g = 0; g < 8; g++)
      for (int r = 0; r < 8; r++)
        for (int b = 0; b < 8; b++) begin
          send({12'(vals[b]), 12'(vals[r]), 12'(vals[g])});
          n++;
          if (n % 7 == 0) begin @(negedge clk); pix_valid_i = 1'b0; end
        end
    drain();
  endtask

  task automatic lat_chk(input string t);
    tag = t;
    send(36'h123456789);
    @(negedge clk); pix_valid_i = 1'b0;
    @(negedge clk); chk(pix_valid_o == 1'b0, {t, " early"}, pix_valid_o, 0);
    @(negedge clk); chk(pix_valid_o == 1'b1, {t, " at 3"}, pix_valid_o, 1);
    drain();
  endtask

  task automatic diag(input int sc, input int g, input int oo);
    p_byp = 0; p_sc = sc; p_w = 0;
    p_io = '{0,0,0}; p_oo = '{oo,oo,oo};
    p_cf = '{g,0,0, 0,g,0, 0,0,g};
  endtask

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; pix_valid_i = 1'b0; pix_data_i = '0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    #1; chk(pix_valid_o == 1'b0, "R2 valid in reset", pix_valid_o, 0);
    @(negedge clk); rst_n = 1'b1;
    rd_chk(8'h80, 8'h05, "R2 control");
    rd_chk(8'h81, 0, "R2 offset");
    rd_chk(8'h9E, 0, "R2 last");
    chk(pix_valid_o == 1'b0, "R2 valid", pix_valid_o, 0);

    // R1: fill the pending bank, read it back with masks
    for (int i = 0; i < 31; i++) wr(8'h80 + i, (i * 37 + 11) & 255);
    for (int i = 0; i < 31; i++)
      rd_chk(8'h80 + i, ((i * 37 + 11) & 255) & (i == 0 ? 8'h1F : (i % 2 == 1 ? 8'h07 : 8'hFF)), "R1 readback");
    rd_chk(8'h7F, 0, "R1 below window");
    rd_chk(8'h9F, 0, "R1 above window");

    // R3: nothing pulsed yet, so still bypass
    lat_chk("R10 bypass latency");
    sweep("R3 pending not applied");

    // R5 R6: unity at select 1
    diag(1, 512, 0); put_cfg(); pulse();
    lat_chk("R10 active latency");
    sweep("R5 R6 unity");

    // R5 R6: full to limited range
    diag(2, 12'h36F, 12'h040); put_cfg(); pulse();
    sweep("R5 R6 limited");

    // R8: signed mix, select 0, clamps both ends
    p_byp = 0; p_sc = 0; p_w = 0;
    p_io = '{-256, 100, 0}; p_oo = '{-100, 50, 1023};
    p_cf = '{300, -500, 700, -1024, 1023, 0, 512, 512, 512};
    put_cfg(); pulse();
    sweep("R8 R5 clamp mix");

    // R6: select 3 with extreme offsets
    p_sc = 3;
    p_io = '{1023, -1024, 5}; p_oo = '{-1024, 0, 1023};
    p_cf = '{1023, -1, -1, -1, 1023, -1, -1, -1, 1023};
    put_cfg(); pulse();
    sweep("R6 R8 select3");

    // R7: rounding at divisor 1024, explicit values
    diag(2, 1, 0); put_cfg(); pulse();
    tag = "R7 rounding";
    send_exp(36'd512, 36'd1);
    send_exp(36'd511, 36'd0);
    send_exp(36'd1535, 36'd1);
    send_exp(36'd1536, 36'd2);
    drain();

    // R9: 10-bit width in active mode, 8-bit in bypass
    diag(2, 12'h36F, 12'h040); p_w = 1; put_cfg(); pulse();
    sweep("R9 width10 active");
    p_byp = 1; p_w = 2; put_cfg(); pulse();
    tag = "R9 width8 bypass";
    send_exp(36'hFFF_FFF_FFF, 36'hFF0_FF0_FF0);
    drain();
    sweep("R9 R4 width8 bypass");

    finish_up();
  end
endmodule